// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block is the central arbiter for a set of masters sharing one bus. Each master has its own active-low request line and its own active-low grant line, and at most one grant is low at any clock. Among competing requesters the arbiter picks the next owner in round-robin order, starting just after the master that was granted most recently. When nobody requests, the grant stays parked on the last master that held it, or on master 0 after reset. A requester on a parked bus can then start a cycle without waiting for arbitration.

The arbiter does not wait for a transaction to end before it moves the grant. Each master is expected to check that the bus is idle (cycle-frame and initiator-ready both high) before it starts. Whenever the owner changes, the arbiter inserts one clock in which no grant is low, so two masters never see their grants overlap.

The controller is a three-state machine:
- `S_RESET` holds all grants high while reset is asserted.
- `S_GRANT` drives one grant low.
- `S_GAP` is the dead clock of a handover.

The transitions are:
- *release* (`S_RESET` to `S_GRANT`) is the first edge after reset.
- *hold* (`S_GRANT` to `S_GRANT`) applies when no other master should take over.
- *handover* (`S_GRANT` to `S_GAP`) applies when the round-robin pick differs from the holder.
- *regrant* (`S_GAP` to `S_GRANT`) completes a handover.

Top module: `bus_park_arbiter`

## Requirements
- R1: At every clock edge outside reset, at most one bit of `gnt_n` is low.
- R2: While `rst_n` is low, all of `gnt_n` is high and `owner_idx` is 0, without waiting for a clock edge.
- R3: At the first rising edge with `rst_n` high, a grant is driven low at once, with no empty clock. It goes to the first requester found by searching upward from master 1 and wrapping around. If nobody requests, it goes to master 0.
- R4: While no bit of `req_n` is low, the grant stays on the master that holds it.
- R5: From holder k, the next owner is the first master with a low request among k+1, k+2 and so on, wrapping past the highest index to 0. The holder keeps the grant only when it is the sole requester.
- R6: At the edge where a request selects a different master, all grants go high for exactly one clock. The selected master's grant goes low at the following edge, and that target does not change during the empty clock.
- R7: `frame_n` and `irdy_n` do not delay or block any grant change. A handover sampled while the bus is busy completes with the same timing as one sampled on an idle bus.
- R8: `owner_idx` equals the index of the master whose grant is low. During the empty clock of a handover, it gives the index of the incoming master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_MASTERS | Active-low bus requests, one per master |
| frame_n | input | 1 | Active-low cycle-frame signal of the shared bus |
| irdy_n | input | 1 | Active-low initiator-ready signal of the shared bus |
| gnt_n | output | N_MASTERS | Active-low grants, one per master |
| owner_idx | output | $clog2(N_MASTERS) | Current or incoming owner index |

## Verification
The bench builds the arbiter with `N_MASTERS` set to 3. With that value the round-robin wrap has to step from index 2 back to 0 through a subtraction rather than a natural overflow of the index, and one code of the two-bit owner index never names a master. Three masters are also enough to show:
- a holder being skipped in favour of the next requester;
- a full rotation while all three request with the bus held busy;
- a pick that jumps over a non-requesting neighbour.

// File: rtl/bus_park_arbiter_pkg.sv
package bus_park_arbiter_pkg;

    typedef enum logic [1:0] {
        S_RESET = 2'd0,
        S_GRANT = 2'd1,
        S_GAP   = 2'd2
    } arb_state_e;

endpackage

// File: rtl/rr_pick.sv
// Round-robin search: first active request after 'last', wrapping; 'last'
// itself is considered only at the end of the search.
module rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int IW = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IW-1:0]        last,
    output logic [IW-1:0]        pick,
    output logic                 any
);
    always_comb begin
        pick = last;
        any  = 1'b0;
        for (int i = 1; i <= N_MASTERS; i++) begin
            int cand;
            cand = int'(last) + i;
            if (cand >= N_MASTERS) cand = cand - N_MASTERS;
            if (!any && req[cand]) begin
                pick = IW'(cand);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gnt_decode.sv
// Turns an owner index and an enable into the active-low grant vector.
module gnt_decode #(
    parameter int N_MASTERS = 4,
    localparam int IW = $clog2(N_MASTERS)
) (
    input  logic                 en,
    input  logic [IW-1:0]        idx,
    output logic [N_MASTERS-1:0] gnt_n
);
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_line
        assign gnt_n[g] = !(en && (idx == IW'(g)));
    end
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import bus_park_arbiter_pkg::*;
#(
    parameter int N_MASTERS = 4,
    localparam int IW = $clog2(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    output logic [N_MASTERS-1:0] gnt_n,
    output logic [IW-1:0]        owner_idx
);
    initial begin
        if (N_MASTERS < 2 || N_MASTERS > 8)
            $error("N_MASTERS must lie between 2 and 8");
    end

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] rr_next;
    logic          rr_any;
    logic          bus_busy;

    assign bus_busy = !frame_n || !irdy_n;

    rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req  (~req_n),
        .last (owner_q),
        .pick (rr_next),
        .any  (rr_any)
    );

    // Next-state logic: release, hold, handover, regrant.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            S_RESET: begin
                state_d = S_GRANT;                    // release
                owner_d = rr_any ? rr_next : '0;
            end
            S_GRANT: begin
                if (rr_any && rr_next != owner_q) begin
                    state_d = S_GAP;                  // handover
                    owner_d = rr_next;
                end
            end
            S_GAP: begin
                state_d = S_GRANT;                    // regrant
            end
            default: begin
                state_d = S_RESET;
                owner_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RESET;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Output logic.
    logic grant_on;
    always_comb begin
        grant_on  = (state_q == S_GRANT);
        owner_idx = owner_q;
    end

    gnt_decode #(.N_MASTERS(N_MASTERS)) u_dec (
        .en    (grant_on),
        .idx   (owner_q),
        .gnt_n (gnt_n)
    );

    // Assertions
    p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n))
        else $error("more than one grant low");

    p_no_direct_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(~$past(gnt_n))) && (|(~gnt_n))) |-> (gnt_n == $past(gnt_n)))
        else $error("grant moved without an empty clock");

    p_gap_one_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |=> ((state_q == S_GRANT) && $stable(owner_idx)))
        else $error("handover gap not exactly one clock");

    p_park_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_GRANT) && (&req_n)) |=> $stable(gnt_n))
        else $error("parked grant moved with no request");

    p_busy_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_GAP) && bus_busy) |=> (|(~gnt_n)))
        else $error("busy bus stalled a handover");

    p_owner_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GRANT) |-> (gnt_n[owner_idx] == 1'b0))
        else $error("owner index does not match grant");
endmodule

// File: tb/tb_bus_park_arbiter.sv
module tb_bus_park_arbiter;
    localparam int N  = 3;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_n = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [N-1:0]  gnt_n;
    logic [IW-1:0] owner_idx;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    bus_park_arbiter #(.N_MASTERS(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n),
        .frame_n(frame_n), .irdy_n(irdy_n),
        .gnt_n(gnt_n), .owner_idx(owner_idx)
    );

    task automatic check(input string req, input logic [N-1:0] exp_g,
                         input logic [IW-1:0] exp_o);
        vectors++;
        if (gnt_n !== exp_g || owner_idx !== exp_o) begin
            errors++;
            $display("FAIL %s: gnt_n=%b owner=%0d expected gnt_n=%b owner=%0d",
                     req, gnt_n, owner_idx, exp_g, exp_o);
        end
        vectors++;
        if ($countones(~gnt_n) > 1) begin
            errors++;
            $display("FAIL R1: gnt_n=%b expected at most one low bit", gnt_n);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_park();
        repeat (3) step();
        check("R2 reset", 3'b111, 0);
        rst_n = 1'b1;
        step();
        check("R3 release parks on 0", 3'b110, 0);
        repeat (3) step();
        check("R4 parked on 0", 3'b110, 0);
    endtask

    task automatic t_handover();
        req_n = 3'b011;
        step();
        check("R6 gap, R8 incoming 2", 3'b111, 2);
        step();
        check("R6 grant 2", 3'b011, 2);
        repeat (2) step();
        check("R5 sole requester keeps", 3'b011, 2);
        req_n = 3'b111;
        repeat (3) step();
        check("R4 parked on 2", 3'b011, 2);
    endtask

    task automatic t_rotate_busy();
        req_n = 3'b000;
        frame_n = 1'b0;
        irdy_n = 1'b0;
        step(); check("R7 gap toward 0", 3'b111, 0);
        step(); check("R5 wrap to 0", 3'b110, 0);
        step(); check("R6 gap toward 1", 3'b111, 1);
        step(); check("R5 grant 1", 3'b101, 1);
        step(); check("R6 gap toward 2", 3'b111, 2);
        step(); check("R5 grant 2", 3'b011, 2);
        step(); check("R7 gap toward 0 busy", 3'b111, 0);
        step(); check("R5 grant 0 again", 3'b110, 0);
        req_n = 3'b111;
        frame_n = 1'b1;
        irdy_n = 1'b1;
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        #1;
        check("R2 async reset", 3'b111, 0);
        req_n = 3'b101;
        step();
        check("R2 held in reset", 3'b111, 0);
        rst_n = 1'b1;
        step();
        check("R3 release direct to 1", 3'b101, 1);
    endtask

    task automatic t_skip();
        req_n = 3'b010;
        step(); check("R5 pick 2 after 1", 3'b111, 2);
        req_n = 3'b110;
        step(); check("R6 target fixed in gap", 3'b011, 2);
        step(); check("R5 wrap to 0 gap", 3'b111, 0);
        step(); check("R5 grant 0", 3'b110, 0);
    endtask

    initial begin
        fork
            begin
                step();
                t_reset_park();
                t_handover();
                t_rotate_busy();
                t_reset_mid();
                t_skip();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                vectors++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule